// File: doc/BRIEF.md
# Peripheral Clock Gate Bank

This block holds the on/off state of up to 64 peripheral clocks and turns each state into a gated clock derived from one parent clock. Peripherals are numbered by ID. Every 32 IDs form one bank, and each bank has three registers: a set register, a clear register and a status register. Software turns a clock on by writing a one to the matching bit of the bank's set register. It turns a clock off by writing a one to the matching bit of the clear register. Zero bits in either write do nothing, so no read-modify-write sequence is needed. The status register shows which clocks are running.

The lowest IDs (two by default) belong to logic that must never stop. They are tied on. Writes cannot change them, and they always read as running. Each gated clock is the parent clock ANDed with an enable captured on the parent's falling edge. A change of state therefore first shows at the next rising edge, and no high phase is ever cut short.

The register port is a plain single-cycle control interface with no handshake. A write happens on any rising edge where the strobe is high. Read data is combinational from the address.

Top module: `periph_clk_gate_bank`

## Requirements
- R1: After reset, every gateable clock is off. Status reads show only the always-on bits set: bank 0 reads 0x00000003 and bank 1 reads 0x00000000.
- R2: A write to a bank's set register (bank 0 at 0x00, bank 1 at 0x10) turns on each clock whose bit is 1. Clocks whose bit is 0 keep their state.
- R3: A write to a bank's clear register (0x04, 0x14) turns off each clock whose bit is 1. Clocks whose bit is 0 keep their state.
- R4: The status register (0x08, 0x18) returns 1 in each bit whose clock is on. The output `clk_en` shows the same state. A peripheral's bit inside its bank is its ID modulo 32.
- R5: IDs 32 to 63 are controlled only through the registers at 0x10, 0x14 and 0x18. IDs 0 to 31 are controlled only through 0x00, 0x04 and 0x08. A write to one bank leaves the other bank unchanged.
- R6: IDs 0 and 1 are always on. Set and clear writes to their bits are ignored.
- R7: Reads of a set or clear register, or of any unmapped address, return 0.
- R8: While `wr_en` is low, no clock changes state, whatever the address and data.
- R9: A state change made at rising edge N appears on `gclk` at rising edge N+1. An enabled `gclk` bit follows the parent clock. A disabled bit stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| rdata | output | 32 | Read data for `addr`, combinational |
| clk_en | output | 64 | Current on/off state for each ID |
| gclk | output | 64 | Gated clock for each ID |

## Verification
The assertions assume that `addr`, `wdata` and `wr_en` change only away from the rising edge, and that a write strobe lasts exactly one cycle with its address already stable. The bench meets this by driving every input on the falling edge and holding each write for one cycle. It also holds the address steady while it samples `rdata`. The sweeps walk every ID through set and clear in both banks and write to the always-on bits. They also pulse writes to unmapped addresses and present data with the strobe low. Every outcome is compared with a bit-vector model kept in the bench.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  // Byte offsets within one bank's register window.
  localparam logic [3:0] OFF_SET = 4'h0;
  localparam logic [3:0] OFF_CLR = 4'h4;
  localparam logic [3:0] OFF_STS = 4'h8;
  // Distance in bytes between two bank windows.
  localparam int BANK_STRIDE = 16;

  typedef enum logic [1:0] {
    RK_NONE,
    RK_SET,
    RK_CLR,
    RK_STS
  } reg_kind_e;
endpackage

// File: rtl/pcg_decode.sv
module pcg_decode
  import pcg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_BANKS = 2,
  localparam int BIDX_W   = ADDR_W - 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BIDX_W-1:0] bank_idx,
  output reg_kind_e         kind
);
  logic [3:0] off;

  assign bank_idx = addr[ADDR_W-1:4];
  assign off      = addr[3:0];

  always_comb begin
    kind = RK_NONE;
    if (int'(bank_idx) < NUM_BANKS) begin
      unique case (off)
        OFF_SET: kind = RK_SET;
        OFF_CLR: kind = RK_CLR;
        OFF_STS: kind = RK_STS;
        default: kind = RK_NONE;
      endcase
    end
  end
endmodule

// File: rtl/pcg_bank.sv
module pcg_bank #(
  parameter int BANK_W     = 32,
  parameter int BASE_ID    = 0,
  parameter int NUM_PERIPH = 64,
  parameter int ALWAYS_ON  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] state
);
  function automatic logic [BANK_W-1:0] calc_on();
    logic [BANK_W-1:0] m;
    m = '0;
    for (int i = 0; i < BANK_W; i++)
      if (BASE_ID + i < ALWAYS_ON && BASE_ID + i < NUM_PERIPH) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [BANK_W-1:0] calc_gate();
    logic [BANK_W-1:0] m;
    m = '0;
    for (int i = 0; i < BANK_W; i++)
      if (BASE_ID + i >= ALWAYS_ON && BASE_ID + i < NUM_PERIPH) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [BANK_W-1:0] ON_MASK   = calc_on();
  localparam logic [BANK_W-1:0] GATE_MASK = calc_gate();

  logic [BANK_W-1:0] st_q, st_d, set_v, clr_v;

  assign set_v = set_we ? wdata : '0;
  assign clr_v = clr_we ? wdata : '0;
  assign st_d  = ((st_q | set_v) & ~clr_v) & GATE_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign state = (st_q & GATE_MASK) | ON_MASK;
endmodule

// File: rtl/pcg_gate.sv
module pcg_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic gclk
);
  // The enable is captured while clk is low, so the AND cannot chop a high phase.
  logic en_lo;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_lo <= 1'b0;
    else        en_lo <= en;
  end

  assign gclk = clk & en_lo;
endmodule

// File: rtl/periph_clk_gate_bank.sv
module periph_clk_gate_bank
  import pcg_pkg::*;
#(
  parameter int NUM_PERIPH = 64,
  parameter int BANK_W     = 32,
  parameter int ALWAYS_ON  = 2,
  parameter int ADDR_W     = 8,
  localparam int NUM_BANKS = (NUM_PERIPH + BANK_W - 1) / BANK_W,
  localparam int BIDX_W    = ADDR_W - 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [BANK_W-1:0]     wdata,
  input  logic                  wr_en,
  output logic [BANK_W-1:0]     rdata,
  output logic [NUM_PERIPH-1:0] clk_en,
  output logic [NUM_PERIPH-1:0] gclk
);
  localparam int TOT_W = NUM_BANKS * BANK_W;

  logic [BIDX_W-1:0] bank_idx;
  reg_kind_e         kind;
  logic [TOT_W-1:0]  all_state;

  pcg_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_dec (
    .addr(addr), .bank_idx(bank_idx), .kind(kind)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = wr_en && (int'(bank_idx) == b);
    pcg_bank #(
      .BANK_W(BANK_W), .BASE_ID(b * BANK_W),
      .NUM_PERIPH(NUM_PERIPH), .ALWAYS_ON(ALWAYS_ON)
    ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .set_we(hit && kind == RK_SET),
      .clr_we(hit && kind == RK_CLR),
      .wdata(wdata),
      .state(all_state[b*BANK_W +: BANK_W])
    );
  end

  always_comb begin
    rdata = '0;
    if (kind == RK_STS) begin
      for (int b = 0; b < NUM_BANKS; b++)
        if (int'(bank_idx) == b) rdata = all_state[b*BANK_W +: BANK_W];
    end
  end

  assign clk_en = all_state[NUM_PERIPH-1:0];

  for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_gate
    pcg_gate u_gate (.clk(clk), .rst_n(rst_n), .en(clk_en[p]), .gclk(gclk[p]));
  end
endmodule

// File: rtl/periph_clk_gate_bank_chk.sv
module periph_clk_gate_bank_chk #(
  parameter int NUM_PERIPH = 64,
  parameter int BANK_W     = 32,
  parameter int ADDR_W     = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [ADDR_W-1:0]     addr,
  input logic [BANK_W-1:0]     wdata,
  input logic                  wr_en,
  input logic [BANK_W-1:0]     rdata,
  input logic [NUM_PERIPH-1:0] clk_en
);
  // R2
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h00) |=> ((clk_en[BANK_W-1:0] & $past(wdata)) == $past(wdata)));

  // R3
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h04) |=> ((clk_en[BANK_W-1:2] & $past(wdata[BANK_W-1:2])) == '0));

  // R6
  always_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en[1:0] == 2'b11);

  // R8
  no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(clk_en));

  // R5
  bank_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[ADDR_W-1:4] != '0) |=> $stable(clk_en[BANK_W-1:0]));

  // R4
  status_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 8'h08) |-> (rdata == clk_en[BANK_W-1:0]));

  // R7
  wo_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[3:0] == 4'h0 || addr[3:0] == 4'h4) |-> (rdata == '0));
endmodule

bind periph_clk_gate_bank periph_clk_gate_bank_chk #(
  .NUM_PERIPH(NUM_PERIPH), .BANK_W(BANK_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
  .wr_en(wr_en), .rdata(rdata), .clk_en(clk_en)
);

// File: tb/periph_clk_gate_bank_tb.sv
`timescale 1ns/1ps
module periph_clk_gate_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = 8'h0;
  logic [31:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic [31:0] rdata;
  logic [63:0] clk_en, gclk;
  logic [63:0] model;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  periph_clk_gate_bank u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rdata(rdata), .clk_en(clk_en), .gclk(gclk)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Apply one write to the model, using the register map from the requirements.
  function automatic logic [63:0] apply(logic [63:0] m, logic [7:0] a, logic [31:0] d);
    logic [63:0] v;
    v = (a[4]) ? {d, 32'h0} : {32'h0, d};
    if (a[7:5] == 3'b0 && a[3:0] == 4'h0) m = m | v;
    if (a[7:5] == 3'b0 && a[3:0] == 4'h4) m = m & ~v;
    m[1:0] = 2'b11;
    return m;
  endfunction

  task automatic do_wr(logic [7:0] a, logic [31:0] d);
    wr(a, d);
    model = apply(model, a, d);
  endtask

  task automatic rd(string req, logic [7:0] a, logic [31:0] exp);
    addr = a; #0.5;
    check(req, {32'h0, rdata}, {32'h0, exp});
  endtask

  task automatic check_state(string req);
    check(req, clk_en, model);
    rd(req, 8'h08, model[31:0]);
    rd(req, 8'h18, model[63:32]);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model = 64'h3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_state("R1");

    // R2 R4 R5: sweep every ID through set, one at a time
    for (int id = 0; id < 64; id++) begin
      logic [7:0] a;
      a = (id >= 32) ? 8'h10 : 8'h00;
      do_wr(a, 32'h1 << (id % 32));
      check_state((id >= 32) ? "R5" : "R2");
    end
    // R3: clear every ID one at a time
    for (int id = 0; id < 64; id++) begin
      do_wr((id >= 32) ? 8'h14 : 8'h04, 32'h1 << (id % 32));
      check_state("R3");
    end
    // R6: always-on bits cannot be cleared
    do_wr(8'h04, 32'hFFFF_FFFF);
    check("R6", {62'h0, clk_en[1:0]}, 64'h3);

    // R2 R3 mixed patterns, zeros leave state alone
    do_wr(8'h00, 32'hA5A5_A5A5);
    do_wr(8'h10, 32'h0F0F_F0F0);
    check_state("R2");
    do_wr(8'h04, 32'h0000_00F0);
    do_wr(8'h14, 32'h3000_0010);
    check_state("R3");

    // R7: set/clear registers and unmapped addresses read 0
    rd("R7", 8'h00, 32'h0);
    rd("R7", 8'h04, 32'h0);
    rd("R7", 8'h14, 32'h0);
    rd("R7", 8'h0C, 32'h0);
    rd("R7", 8'h28, 32'h0);
    // R7: writes to unmapped addresses change nothing
    do_wr(8'h20, 32'hFFFF_FFFF);
    do_wr(8'h0C, 32'hFFFF_FFFF);
    check_state("R7");

    // R8: strobe low, no change
    @(negedge clk);
    addr = 8'h00; wdata = 32'hFFFF_FFFF; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    check_state("R8");

    // R9: gated clock follows enable one edge later
    do_wr(8'h04, 32'hFFFF_FFFC);
    do_wr(8'h00, 32'h0000_0020);  // ID 5 on at edge N
    @(posedge clk); #0.5;
    check("R9", {63'h0, gclk[5]}, 64'h1);
    check("R9", {63'h0, gclk[6]}, 64'h0);
    check("R9", {63'h0, gclk[0]}, 64'h1);
    @(negedge clk); #0.5;
    check("R9", {63'h0, gclk[5]}, 64'h0);
    do_wr(8'h04, 32'h0000_0020);
    @(posedge clk); #0.5;
    check("R9", {63'h0, gclk[5]}, 64'h0);

    // R1 again: reset mid-run clears gateable state
    do_wr(8'h00, 32'hFFFF_FFFF);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    model = 64'h3;
    check_state("R1");

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule